// File: doc/BRIEF.md
# Boot-Remappable System Address Decoder

This block sits between a processor's request port and the on-chip targets. It takes a 32-bit byte address and turns it into a one-hot target select and an offset inside that target. The targets are the flash array, the SRAM array, the peripheral register window, four external memory regions, and a reserved-address error response. It also paces each access: it raises `ready_o` after the number of cycles that the bus behind the target needs.

The lowest 64 kB of the address space is an alias window. After reset, it maps onto flash, so a processor can boot from address zero. Writing 0 to bit 0 of the remap control register makes the window map onto SRAM instead. In that case, window addresses fold modulo the SRAM size. Accesses to the memories, to the external regions and to a few fast register blocks (port I/O, flash control and pulse-width modulator) finish in one cycle. All other register accesses go over the slower peripheral bus and take two cycles.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset, `sel_o` and `ready_o` are low, and the remap bit is 1. A request to 0x00000000–0x0000FFFF then selects flash (sel bit 0), with offset equal to address bits [15:0].
- R2: A write on the remap port loads only data bit 0. With the bit at 0, the low window selects SRAM (sel bit 1) with offset address[12:0], so addresses past 8 kB wrap. Writing 1 restores the flash alias.
- R3: Flash at 0x00080000–0x0008FFFF (offset address[15:0]) and SRAM at 0x00010000–0x00011FFF (offset address[12:0]) decode the same way for either remap value.
- R4: Addresses 0xFFFF0000–0xFFFFFFFF select the register window (sel bit 2), with offset address[15:0].
- R5: The 64 kB regions at 0x10000000, 0x20000000, 0x30000000 and 0x40000000 select sel bits 3, 4, 5 and 6 respectively, with offset address[15:0].
- R6: Any other address selects sel bit 7, raises `err_o` and gives offset 0.
- R7: `sel_o` is zero when no access is in flight. Otherwise exactly one bit is set, from the cycle after the request is taken through the cycle in which `ready_o` is high.
- R8: Flash, SRAM, external, reserved and fast register blocks complete in one cycle: `ready_o` is high in the cycle right after the request cycle. The fast register blocks are the 1 kB blocks at 0xFFFFF400, 0xFFFFF800 and 0xFFFFFC00.
- R9: All other register window addresses complete in two cycles. `ready_o` is low for one cycle and then high for one cycle.
- R10: `ready_o` is high for exactly one cycle per access. A request presented while a two-cycle access is waiting is ignored: it produces no select and no ready.
- R11: A remap write in the same cycle as a low-window request does not affect that request. The request decodes with the previous remap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | 32 | Byte address of the request |
| remap_we_i | input | 1 | Remap control register write enable |
| remap_wdata_i | input | 32 | Remap write data (bit 0 used) |
| sel_o | output | 8 | One-hot target select |
| ofs_o | output | 16 | Offset inside the selected target |
| err_o | output | 1 | Reserved-address access |
| ready_o | output | 1 | Access completion pulse |

## Verification
The hardest situation to reach from the ports is a request that arrives during the wait cycle of a two-cycle register access. To reach it, the bench starts a slow access and presents a flash request exactly one cycle later. It then confirms that only one ready pulse appears and that the select clears afterwards. The same-cycle case of a remap write beside a low-window request is reached by driving both strobes on the same clock edge, and then repeating the request to see the new alias take effect.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int ADDR_W = 32;
    localparam int OFS_W  = 16;
    localparam int N_EXT  = 4;
    localparam int N_TGT  = 4 + N_EXT;

    localparam int T_FLASH = 0;
    localparam int T_SRAM  = 1;
    localparam int T_MMR   = 2;
    localparam int T_EXT0  = 3;
    localparam int T_ERR   = N_TGT - 1;

    typedef struct packed {
        logic [N_TGT-1:0] sel;
        logic [OFS_W-1:0] ofs;
        logic             slow;
    } dec_t;
endpackage

// File: rtl/sad_remap_reg.sv
module sad_remap_reg #(
    parameter int   DATA_W  = 32,
    parameter logic RST_VAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              remap_o
);
    typedef struct packed {
        logic remap;
    } rr_t;

    rr_t rr_d, rr_q;

    wire unused_hi = ^wdata_i[DATA_W-1:1];

    always_comb begin
        rr_d = rr_q;
        if (we_i) begin
            rr_d.remap = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q.remap <= RST_VAL;
        end else begin
            rr_q <= rr_d;
        end
    end

    assign remap_o = rr_q.remap;

    p_remap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(remap_o));
    p_remap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (remap_o == $past(wdata_i[0])));
endmodule

// File: rtl/sad_region_dec.sv
module sad_region_dec
    import sad_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOW_BASE   = 32'h0000_0000,
    parameter int                LOW_AW     = 16,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0008_0000,
    parameter int                FLASH_AW   = 16,
    parameter logic [ADDR_W-1:0] SRAM_BASE  = 32'h0001_0000,
    parameter int                SRAM_AW    = 13,
    parameter logic [ADDR_W-1:0] MMR_BASE   = 32'hFFFF_0000,
    parameter int                MMR_AW     = 16,
    parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] EXT_STEP   = 32'h1000_0000,
    parameter int                EXT_AW     = 16,
    parameter int                N_FAST     = 3,
    parameter int                FAST_AW    = 10,
    parameter logic [N_FAST*ADDR_W-1:0] FAST_BASES =
        {32'hFFFF_FC00, 32'hFFFF_F800, 32'hFFFF_F400}
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              remap_i,
    output dec_t              dec_o
);
    logic              low_hit, flash_hit, sram_hit, mmr_hit;
    logic [N_EXT-1:0]  ext_hit;
    logic [N_FAST-1:0] fast_hit;

    assign low_hit   = addr_i[ADDR_W-1:LOW_AW]   == LOW_BASE[ADDR_W-1:LOW_AW];
    assign flash_hit = addr_i[ADDR_W-1:FLASH_AW] == FLASH_BASE[ADDR_W-1:FLASH_AW];
    assign sram_hit  = addr_i[ADDR_W-1:SRAM_AW]  == SRAM_BASE[ADDR_W-1:SRAM_AW];
    assign mmr_hit   = addr_i[ADDR_W-1:MMR_AW]   == MMR_BASE[ADDR_W-1:MMR_AW];

    for (genvar e = 0; e < N_EXT; e++) begin : g_ext
        localparam logic [ADDR_W-1:0] BASE_E = EXT_BASE + EXT_STEP * e;
        assign ext_hit[e] = addr_i[ADDR_W-1:EXT_AW] == BASE_E[ADDR_W-1:EXT_AW];
    end

    for (genvar f = 0; f < N_FAST; f++) begin : g_fast
        localparam logic [ADDR_W-1:0] BASE_F = FAST_BASES[f*ADDR_W +: ADDR_W];
        assign fast_hit[f] = addr_i[ADDR_W-1:FAST_AW] == BASE_F[ADDR_W-1:FAST_AW];
    end

    always_comb begin
        dec_o      = '0;
        dec_o.slow = 1'b0;
        if (low_hit) begin
            if (remap_i) begin
                dec_o.sel[T_FLASH] = 1'b1;
                dec_o.ofs          = OFS_W'(addr_i[LOW_AW-1:0]);
            end else begin
                dec_o.sel[T_SRAM]  = 1'b1;
                dec_o.ofs          = OFS_W'(addr_i[SRAM_AW-1:0]);
            end
        end else if (flash_hit) begin
            dec_o.sel[T_FLASH] = 1'b1;
            dec_o.ofs          = OFS_W'(addr_i[FLASH_AW-1:0]);
        end else if (sram_hit) begin
            dec_o.sel[T_SRAM] = 1'b1;
            dec_o.ofs         = OFS_W'(addr_i[SRAM_AW-1:0]);
        end else if (mmr_hit) begin
            dec_o.sel[T_MMR] = 1'b1;
            dec_o.ofs        = OFS_W'(addr_i[MMR_AW-1:0]);
            dec_o.slow       = ~|fast_hit;
        end else if (|ext_hit) begin
            for (int e = 0; e < N_EXT; e++) begin
                dec_o.sel[T_EXT0+e] = ext_hit[e];
            end
            dec_o.ofs = OFS_W'(addr_i[EXT_AW-1:0]);
        end else begin
            dec_o.sel[T_ERR] = 1'b1;
        end
    end

    always_comb begin
        if (!$isunknown(addr_i)) begin
            p_dec_onehot_r7: assert ($onehot(dec_o.sel));
        end
    end
endmodule

// File: rtl/sad_wait_ctl.sv
module sad_wait_ctl
    import sad_pkg::*;
#(
    parameter int FAST_CYC = 1,
    parameter int SLOW_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  dec_t             dec_i,
    output logic [N_TGT-1:0] sel_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             ready_o
);
    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             ready;
        logic [N_TGT-1:0] sel;
        logic [OFS_W-1:0] ofs;
    } st_t;

    st_t st_d, st_q;
    int  cyc;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        cyc        = dec_i.slow ? SLOW_CYC : FAST_CYC;
        if (st_q.busy) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.ready = 1'b1;
            end
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else if (req_i) begin
            st_d.sel = dec_i.sel;
            st_d.ofs = dec_i.ofs;
            if (cyc <= 1) begin
                st_d.busy  = 1'b0;
                st_d.cnt   = '0;
                st_d.ready = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(cyc - 1);
            end
        end else begin
            st_d.sel = '0;
            st_d.ofs = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o   = st_q.sel;
    assign ofs_o   = st_q.ofs;
    assign ready_o = st_q.ready;

    p_wait_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !ready_o);
    p_sel_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(sel_o));
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    p_ready_has_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (sel_o != '0));
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import sad_pkg::*;
#(
    parameter int FAST_CYC = 1,
    parameter int SLOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              remap_we_i,
    input  logic [31:0]       remap_wdata_i,
    output logic [N_TGT-1:0]  sel_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              err_o,
    output logic              ready_o
);
    logic remap;
    dec_t dec;

    sad_remap_reg #(.DATA_W(32), .RST_VAL(1'b1)) u_remap (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (remap_we_i),
        .wdata_i (remap_wdata_i),
        .remap_o (remap)
    );

    sad_region_dec u_dec (
        .addr_i  (req_addr_i),
        .remap_i (remap),
        .dec_o   (dec)
    );

    sad_wait_ctl #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_valid_i),
        .dec_i   (dec),
        .sel_o   (sel_o),
        .ofs_o   (ofs_o),
        .ready_o (ready_o)
    );

    assign err_o = sel_o[T_ERR];

    p_err_no_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ofs_o == '0));
endmodule

// File: tb/tb_boot_remap_decoder.sv
module tb_boot_remap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        remap_we_i = 1'b0;
    logic [31:0] remap_wdata_i = '0;
    logic [7:0]  sel_o;
    logic [15:0] ofs_o;
    logic        err_o;
    logic        ready_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    boot_remap_decoder dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid_i),
        .req_addr_i    (req_addr_i),
        .remap_we_i    (remap_we_i),
        .remap_wdata_i (remap_wdata_i),
        .sel_o         (sel_o),
        .ofs_o         (ofs_o),
        .err_o         (err_o),
        .ready_o       (ready_o)
    );

    // {remap, addr, expected sel, expected offset, expected cycles}
    localparam int NV = 22;
    localparam logic [58:0] VEC [NV] = '{
        {1'b1, 32'h0000_0004, 8'h01, 16'h0004, 2'd1}, // R1
        {1'b1, 32'h0000_FFFE, 8'h01, 16'hFFFE, 2'd1}, // R1
        {1'b0, 32'h0000_2004, 8'h02, 16'h0004, 2'd1}, // R2 wrap
        {1'b0, 32'h0000_FFFF, 8'h02, 16'h1FFF, 2'd1}, // R2
        {1'b0, 32'h0008_0010, 8'h01, 16'h0010, 2'd1}, // R3
        {1'b1, 32'h0008_FFFF, 8'h01, 16'hFFFF, 2'd1}, // R3
        {1'b1, 32'h0001_0000, 8'h02, 16'h0000, 2'd1}, // R3
        {1'b0, 32'h0001_1FFF, 8'h02, 16'h1FFF, 2'd1}, // R3
        {1'b1, 32'h0009_0000, 8'h80, 16'h0000, 2'd1}, // R6
        {1'b1, 32'h0001_2000, 8'h80, 16'h0000, 2'd1}, // R6
        {1'b1, 32'h1000_0020, 8'h08, 16'h0020, 2'd1}, // R5
        {1'b1, 32'h2000_FFFF, 8'h10, 16'hFFFF, 2'd1}, // R5
        {1'b1, 32'h3000_1234, 8'h20, 16'h1234, 2'd1}, // R5
        {1'b1, 32'h4000_0000, 8'h40, 16'h0000, 2'd1}, // R5
        {1'b1, 32'h4001_0000, 8'h80, 16'h0000, 2'd1}, // R6
        {1'b1, 32'h5000_0000, 8'h80, 16'h0000, 2'd1}, // R6
        {1'b1, 32'hFFFF_0040, 8'h04, 16'h0040, 2'd2}, // R4 R9
        {1'b1, 32'hFFFF_F404, 8'h04, 16'hF404, 2'd1}, // R8
        {1'b1, 32'hFFFF_F810, 8'h04, 16'hF810, 2'd1}, // R8
        {1'b1, 32'hFFFF_FC10, 8'h04, 16'hFC10, 2'd1}, // R8
        {1'b1, 32'hFFFF_F000, 8'h04, 16'hF000, 2'd2}, // R9
        {1'b1, 32'hFFFE_FFFC, 8'h80, 16'h0000, 2'd1}  // R6
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_remap(input logic [31:0] data);
        @(negedge clk);
        remap_we_i    = 1'b1;
        remap_wdata_i = data;
        @(negedge clk);
        remap_we_i    = 1'b0;
    endtask

    task automatic access(input logic [31:0] addr, input logic [7:0] esel,
                          input logic [15:0] eofs, input int ecyc, input string req);
        int n;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_addr_i  = addr;
        @(negedge clk);
        req_valid_i = 1'b0;
        n = 1;
        while (!ready_o && n < 5) begin
            check(sel_o == esel, req, 32'(sel_o), 32'(esel));
            @(negedge clk);
            n++;
        end
        check(n == ecyc, req, 32'(n), 32'(ecyc));
        check(sel_o == esel, req, 32'(sel_o), 32'(esel));
        check(ofs_o == eofs, req, 32'(ofs_o), 32'(eofs));
        check(err_o == esel[7], {req, " R6 err"}, 32'(err_o), 32'(esel[7]));
        @(negedge clk);
        check(sel_o == 8'h00 && !ready_o, {req, " R7/R10 idle"},
              {23'd0, ready_o, sel_o}, 32'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic cur_remap;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sel_o == 8'h00, "R1 reset sel", 32'(sel_o), 32'd0);
        check(!ready_o && !err_o, "R1 reset ready", 32'(ready_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sel_o == 8'h00, "R1 idle sel", 32'(sel_o), 32'd0);
        access(32'h0000_0100, 8'h01, 16'h0100, 1, "R1 boot alias");

        cur_remap = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][58] != cur_remap) begin
                write_remap({31'd0, VEC[i][58]});
                cur_remap = VEC[i][58];
            end
            access(VEC[i][57:26], VEC[i][25:18], VEC[i][17:2], int'(VEC[i][1:0]),
                   "R2/R3/R4/R5/R6/R8/R9 vector");
        end

        // R2: only bit 0 of the write data counts
        write_remap(32'hFFFF_FFFE);
        access(32'h0000_3008, 8'h02, 16'h1008, 1, "R2 upper bits ignored");
        write_remap(32'h0000_0001);
        access(32'h0000_3008, 8'h01, 16'h3008, 1, "R2 restore flash");

        // R11: remap write beside a low-window request uses old value
        @(negedge clk);
        req_valid_i   = 1'b1;
        req_addr_i    = 32'h0000_4004;
        remap_we_i    = 1'b1;
        remap_wdata_i = 32'h0;
        @(negedge clk);
        req_valid_i = 1'b0;
        remap_we_i  = 1'b0;
        check(ready_o && sel_o == 8'h01, "R11 old remap", 32'(sel_o), 32'h01);
        access(32'h0000_4004, 8'h02, 16'h0004, 1, "R11 new remap");
        write_remap(32'h1);

        // R10: request during the wait cycle is ignored
        @(negedge clk);
        req_valid_i = 1'b1;
        req_addr_i  = 32'hFFFF_0100;
        @(negedge clk);
        req_addr_i  = 32'h0008_0000;
        check(!ready_o && sel_o == 8'h04, "R10 waiting", 32'(sel_o), 32'h04);
        @(negedge clk);
        req_valid_i = 1'b0;
        check(ready_o && sel_o == 8'h04, "R10 slow done", 32'(sel_o), 32'h04);
        @(negedge clk);
        check(!ready_o && sel_o == 8'h00, "R10 no extra ready",
              {23'd0, ready_o, sel_o}, 32'd0);

        // R8 back-to-back single-cycle accesses
        @(negedge clk);
        req_valid_i = 1'b1;
        req_addr_i  = 32'h1000_0000;
        @(negedge clk);
        req_addr_i  = 32'h4000_0004;
        check(ready_o && sel_o == 8'h08, "R8 b2b first", 32'(sel_o), 32'h08);
        @(negedge clk);
        req_valid_i = 1'b0;
        check(ready_o && sel_o == 8'h40 && ofs_o == 16'h0004, "R8 b2b second",
              32'(sel_o), 32'h40);
        @(negedge clk);
        check(!ready_o, "R10 b2b end", 32'(ready_o), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule